// File: doc/BRIEF.md
# Flash Interrupt and Status Register

This block keeps three pieces of state for a flash controller: the interrupt status word, the four controller error flags and the system configuration word. The command engine reports finished operations and failures through single-cycle set pulses. The host reads and writes the interrupt and configuration registers over a simple register port. The block drives the interrupt and ready pins from that state.

The block also gates command writes. A command the host writes goes through as a one-cycle `cmd_go` strobe only when the master interrupt bit is clear. A synchronous active-low reset loads the cold values. A separate warm-reset input loads the warm values.

Register select codes on `host_sel`: 0 is the interrupt status, 1 is the configuration, 2 is the controller status (read only) and 3 is the command. Reading select 3 returns zero.

Top module: `flash_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, the interrupt status becomes 0x8080, the configuration becomes 0x40C0 and all error flags clear. After that, `irq_o` and `rdy_o` are both 1.
- R2: A cycle with `warm_rst` high loads interrupt status 0x8010 and configuration 0x40C0, and clears every error flag.
- R3: Completion pulses `ev_done[3]` (load), `ev_done[2]` (program), `ev_done[1]` (erase) and `ev_done[0]` (reset) set interrupt status bits 7, 6, 5 and 4. Each pulse also sets master bit 15. The new bits are readable in the next cycle.
- R4: Error pulses `ev_err[0]` (command), `ev_err[1]` (erase), `ev_err[2]` (program) and `ev_err[3]` (load) set controller status bits 10, 11, 12 and 13. Each pulse also sets interrupt bit 15.
- R5: A host write to the interrupt register replaces the status with the status AND the written value. Such a write never sets a bit.
- R6: When an interrupt register write leaves bit 15 clear, all four error flags clear. Error flags are never set while bit 15 is clear.
- R7: `irq_o` equals interrupt bit 15 XOR the inverse of configuration bit 6. Configuration bit 6 set makes the pin active-high; clear makes it active-low.
- R8: `rdy_o` equals configuration bit 7.
- R9: A configuration write stores all 16 bits. A read of the configuration register returns the stored value with bits 4..0 forced to zero.
- R10: A write to the command register raises `cmd_go` in that cycle, with `cmd_code` equal to the written value, only when interrupt bit 15 is clear. Otherwise the write is ignored.
- R11: When an interrupt write and set pulses fall in the same cycle, the new status is (old AND written value) OR the pulsed bits. An error pulse in that cycle survives the clear.
- R12: A warm reset takes precedence over a host write and over set pulses in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low cold reset |
| warm_rst | input | 1 | Synchronous warm reset request |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 2 | Register select (0 int, 1 cfg, 2 status, 3 command) |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Read data of the selected register |
| ev_done | input | 4 | Completion pulses: [3] load, [2] program, [1] erase, [0] reset |
| ev_err | input | 4 | Error pulses: [3] load, [2] program, [1] erase, [0] command |
| irq_o | output | 1 | Interrupt pin, polarity set by configuration bit 6 |
| rdy_o | output | 1 | Ready pin |
| cmd_go | output | 1 | Accepted-command strobe |
| cmd_code | output | 16 | Command value presented with `cmd_go` |

## Verification
Two functions can land in the same cycle: the host's AND-mask write to the interrupt register and a completion or error set pulse from the engine. The vector table drives both in one cycle. One case masks everything to zero while a load pulse arrives. Another masks while a command-error pulse arrives. The expected status is (old AND mask) OR set, and the error flag must survive. A further directed case stacks a warm reset on top of a configuration write and an error pulse, and checks that the warm values win.

// File: rtl/flash_irq_pkg.sv
// Package: shared widths, bit positions, reset values and register selects
// for the flash interrupt/status register block.
package flash_irq_pkg;
    localparam int DATA_W     = 16;
    localparam int N_DONE     = 4;
    localparam int N_ERR      = 4;
    localparam int MASTER_BIT = 15;
    localparam int DONE_LSB   = 4;   // done bits occupy 7..4
    localparam int ERR_LSB    = 10;  // error bits occupy 13..10
    localparam int POL_BIT    = 6;
    localparam int RDY_BIT    = 7;
    localparam int CFG_HIDE_W = 5;   // low bits read as zero

    localparam logic [DATA_W-1:0] CFG_RST  = 16'h40C0;
    localparam logic [DATA_W-1:0] INT_COLD = 16'h8080;
    localparam logic [DATA_W-1:0] INT_WARM = 16'h8010;

    typedef enum logic [1:0] {
        SEL_INT  = 2'd0,
        SEL_CFG  = 2'd1,
        SEL_STAT = 2'd2,
        SEL_CMD  = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/flash_irq_status.sv
// Module: flash_irq_status
// Holds the interrupt status word and the error flags. Host writes AND-mask
// the status; engine pulses OR into it in the same cycle. Clearing the master
// bit by a write wipes the error flags. Assumes set pulses last one cycle.
module flash_irq_status
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              wr_int,
    input  logic [DATA_W-1:0] wdata,
    input  logic [N_DONE-1:0] done,
    input  logic [N_ERR-1:0]  err,
    output logic [DATA_W-1:0] int_q,
    output logic [N_ERR-1:0]  err_q
);
    logic [DATA_W-1:0] set_vec;
    logic [DATA_W-1:0] int_n;
    logic [N_ERR-1:0]  err_n;

    // Build the next status: mask by host write, then OR in engine events.
    always_comb begin
        set_vec = '0;
        set_vec[DONE_LSB +: N_DONE] = done;
        set_vec[MASTER_BIT] = (|done) | (|err);
        int_n = (wr_int ? (int_q & wdata) : int_q) | set_vec;
        if (wr_int && !int_n[MASTER_BIT])
            err_n = '0;
        else
            err_n = err_q | err;
    end

    // Register the status and error flags with cold/warm reset priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_q <= INT_COLD;
            err_q <= '0;
        end else if (warm_rst) begin
            int_q <= INT_WARM;
            err_q <= '0;
        end else begin
            int_q <= int_n;
            err_q <= err_n;
        end
    end

    AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst && done[N_DONE-1]) |=> (int_q[DONE_LSB+N_DONE-1] && int_q[MASTER_BIT])); // R3
    AST_ERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (!warm_rst && err[0]) |=> (err_q[0] && int_q[MASTER_BIT])); // R4
    AST_AND_NEVER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_int && done == '0 && err == '0 && !warm_rst) |=> ((int_q & ~$past(int_q)) == '0)); // R5
    AST_NO_ERR_WITHOUT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !int_q[MASTER_BIT] |-> (err_q == '0)); // R6
endmodule

// File: rtl/flash_irq_cfg.sv
// Module: flash_irq_cfg
// Stores the system configuration word, written whole by the host and loaded
// with its reset value on cold or warm reset. Assumes one writer (the host).
module flash_irq_cfg
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              wr_cfg,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    // Capture host writes; both reset kinds restore the default word.
    always_ff @(posedge clk) begin
        if (!rst_n || warm_rst)
            cfg_q <= CFG_RST;
        else if (wr_cfg)
            cfg_q <= wdata;
    end

    AST_WARM_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        warm_rst |=> (cfg_q == CFG_RST)); // R2
endmodule

// File: rtl/flash_irq_ctrl.sv
// Module: flash_irq_ctrl (top)
// Decodes host register accesses, drives the interrupt and ready pins, and
// passes a command to the engine only while the master interrupt is clear.
// Assumes host_sel is stable while host_wr is high.
module flash_irq_ctrl
    import flash_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              warm_rst,
    input  logic              host_wr,
    input  logic [1:0]        host_sel,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic [N_DONE-1:0] ev_done,
    input  logic [N_ERR-1:0]  ev_err,
    output logic              irq_o,
    output logic              rdy_o,
    output logic              cmd_go,
    output logic [DATA_W-1:0] cmd_code
);
    reg_sel_e          sel;
    logic [DATA_W-1:0] int_q;
    logic [N_ERR-1:0]  err_q;
    logic [DATA_W-1:0] cfg_q;
    logic [DATA_W-1:0] stat_word;

    assign sel = reg_sel_e'(host_sel);

    flash_irq_status u_status (
        .clk    (clk),
        .rst_n  (rst_n),
        .warm_rst(warm_rst),
        .wr_int (host_wr && sel == SEL_INT),
        .wdata  (host_wdata),
        .done   (ev_done),
        .err    (ev_err),
        .int_q  (int_q),
        .err_q  (err_q)
    );

    flash_irq_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .warm_rst(warm_rst),
        .wr_cfg  (host_wr && sel == SEL_CFG),
        .wdata   (host_wdata),
        .cfg_q   (cfg_q)
    );

    // Place the error flags at their status-word positions.
    always_comb begin
        stat_word = '0;
        stat_word[ERR_LSB +: N_ERR] = err_q;
    end

    // Read multiplexer; configuration reads hide the low bits.
    always_comb begin
        case (sel)
            SEL_INT:  host_rdata = int_q;
            SEL_CFG:  host_rdata = {cfg_q[DATA_W-1:CFG_HIDE_W], {CFG_HIDE_W{1'b0}}};
            SEL_STAT: host_rdata = stat_word;
            default:  host_rdata = '0;
        endcase
    end

    // Pins: polarity-selected interrupt and ready from the configuration.
    always_comb begin
        irq_o = int_q[MASTER_BIT] ^ ~cfg_q[POL_BIT];
        rdy_o = cfg_q[RDY_BIT];
    end

    // Command gate: forward a command only when no interrupt is pending.
    always_comb begin
        cmd_go   = host_wr && (sel == SEL_CMD) && !int_q[MASTER_BIT];
        cmd_code = host_wdata;
    end

    AST_RDY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && sel == SEL_CFG && !warm_rst) |=> (rdy_o == $past(host_wdata[RDY_BIT]))); // R8
    AST_CFG_READ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_CFG) |-> (host_rdata[CFG_HIDE_W-1:0] == '0)); // R9
endmodule

// File: tb/flash_irq_ctrl_bench.sv
`timescale 1ns/100ps
module flash_irq_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n, warm_rst, host_wr;
    logic [1:0]  host_sel;
    logic [15:0] host_wdata, host_rdata, cmd_code;
    logic [3:0]  ev_done, ev_err;
    logic        irq_o, rdy_o, cmd_go;
    int          n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;  // 250 MHz

    flash_irq_ctrl u_flash_irq_ctrl (.*);

    // {int write, mask, events {err[3:0],done[3:0]}, expected int, expected status}
    localparam logic [56:0] VEC [15] = '{
        {1'b1, 16'h0000, 8'h00, 16'h0000, 16'h0000},  // R5 R6
        {1'b0, 16'h0000, 8'h08, 16'h8080, 16'h0000},  // R3 load
        {1'b1, 16'h7FFF, 8'h00, 16'h0080, 16'h0000},  // R5
        {1'b0, 16'h0000, 8'h04, 16'h80C0, 16'h0000},  // R3 program
        {1'b1, 16'h00FF, 8'h00, 16'h00C0, 16'h0000},  // R5
        {1'b0, 16'h0000, 8'h02, 16'h80E0, 16'h0000},  // R3 erase
        {1'b0, 16'h0000, 8'h01, 16'h80F0, 16'h0000},  // R3 reset
        {1'b0, 16'h0000, 8'h50, 16'h80F0, 16'h1400},  // R4 cmd+prog
        {1'b1, 16'hFFFF, 8'h00, 16'h80F0, 16'h1400},  // R5 R6 master kept
        {1'b1, 16'h7F0F, 8'h00, 16'h0000, 16'h0000},  // R6 wipe
        {1'b0, 16'h0000, 8'hA0, 16'h8000, 16'h2800},  // R4 erase+load
        {1'b1, 16'h0000, 8'h08, 16'h8080, 16'h2800},  // R11 mask with load
        {1'b1, 16'h0000, 8'h00, 16'h0000, 16'h0000},  // R6
        {1'b1, 16'h00F0, 8'h10, 16'h8000, 16'h0400},  // R11 mask with error
        {1'b1, 16'h0000, 8'h00, 16'h0000, 16'h0000}   // R6
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_sel = sel; host_wdata = d;
        @(posedge clk); #1;
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [15:0] v);
        host_sel = sel; #0.5; v = host_rdata;
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [15:0] v;
        rst_n = 1'b0; warm_rst = 1'b0; host_wr = 1'b0; host_sel = 2'd0;
        host_wdata = '0; ev_done = '0; ev_err = '0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1; #0.5;
        rd(2'd0, v); chk("R1 int", v, 16'h8080);
        rd(2'd1, v); chk("R1 cfg", v, 16'h40C0);
        rd(2'd2, v); chk("R1 err", v, 16'h0000);
        chk("R1 irq", {15'd0, irq_o}, 16'd1);
        chk("R1 rdy", {15'd0, rdy_o}, 16'd1);

        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            host_wr = VEC[i][56]; host_sel = 2'd0; host_wdata = VEC[i][55:40];
            {ev_err, ev_done} = VEC[i][39:32];
            @(posedge clk); #1;
            host_wr = 1'b0; ev_done = '0; ev_err = '0;
            rd(2'd0, v); chk($sformatf("R3/R5/R11 vec%0d int", i), v, VEC[i][31:16]);
            rd(2'd2, v); chk($sformatf("R4/R6 vec%0d status", i), v, VEC[i][15:0]);
        end

        // Polarity and ready (status now 0x0000)
        host_write(2'd1, 16'h0000); #0.5;
        chk("R7 low-active idle", {15'd0, irq_o}, 16'd1);
        chk("R8 rdy off", {15'd0, rdy_o}, 16'd0);
        host_write(2'd1, 16'h0040); #0.5;
        chk("R7 high-active idle", {15'd0, irq_o}, 16'd0);
        @(negedge clk); ev_done = 4'b1000; @(posedge clk); #1; ev_done = '0; #0.5;
        chk("R7 high-active pending", {15'd0, irq_o}, 16'd1);
        host_write(2'd1, 16'h00FF);
        rd(2'd1, v); chk("R9 cfg read masked", v, 16'h00E0);
        chk("R8 rdy on", {15'd0, rdy_o}, 16'd1);

        // Command gate (bit 15 currently set)
        @(negedge clk); host_wr = 1'b1; host_sel = 2'd3; host_wdata = 16'h0094; #1;
        chk("R10 blocked", {15'd0, cmd_go}, 16'd0);
        @(posedge clk); #1; host_wr = 1'b0;
        host_write(2'd0, 16'h0000);
        @(negedge clk); host_wr = 1'b1; host_sel = 2'd3; host_wdata = 16'h0094; #1;
        chk("R10 accepted", {15'd0, cmd_go}, 16'd1);
        chk("R10 code", cmd_code, 16'h0094);
        @(posedge clk); #1; host_wr = 1'b0;

        // Warm reset against a config write and an error pulse
        @(negedge clk);
        warm_rst = 1'b1; host_wr = 1'b1; host_sel = 2'd1; host_wdata = 16'h0000; ev_err = 4'b0001;
        @(posedge clk); #1;
        warm_rst = 1'b0; host_wr = 1'b0; ev_err = '0;
        rd(2'd0, v); chk("R2 R12 warm int", v, 16'h8010);
        rd(2'd1, v); chk("R2 R12 warm cfg", v, 16'h40C0);
        rd(2'd2, v); chk("R2 R12 warm err", v, 16'h0000);

        // Cold reset again
        @(negedge clk); rst_n = 1'b0; @(posedge clk); #1; rst_n = 1'b1;
        rd(2'd0, v); chk("R1 cold int again", v, 16'h8080);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule